// File: doc/BRIEF.md
# Wake-up External Interrupt Controller

The block watches 28 asynchronous pad lines and turns chosen events on them into latched pending bits. Each line is first brought into the clock domain by a two-stage synchroniser. Its trigger mode is then set by a 4-bit code. One code is shared by each pair of adjacent lines. The available modes are low level, high level, falling edge, rising edge and both edges.

A detected event sets the line's pending bit. Pending bits are captured whether or not the line is masked. Software clears them by writing ones.

Four level interrupt requests each combine a fixed, uneven range of lines. The ranges hold 4, 8, 8 and 8 lines. A request is high while any line in its range is both pending and unmasked.

Software reaches the trigger codes, the mask and the pending bits through a small register port. The port has an address, a write strobe, write data and combinational read data. The pads are assumed idle high, and the synchroniser comes out of reset at that idle value.

Top module: `wake_irq_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, both trigger words read 0, the mask word reads 0x0FFFFFFF (every line blocked), the pending word reads 0 and all four requests are low, provided the pads are held high.
- R2: Registers sit at byte addresses 0x0 (trigger codes for lines 0–15), 0x4 (trigger codes for lines 16–27), 0x8 (mask, bit n for line n) and 0xC (pending, bit n for line n). Bits 28–31 of mask and pending and bits 24–31 of the second trigger word read as zero. An address with bit 1 or bit 0 set is neither written nor read (it reads zero).
- R3: Line n takes its 4-bit code from bit 4·((n mod 16)/2) of trigger word n/16, so lines 2k and 2k+1 always share one mode.
- R4: Code 2 detects a falling edge, code 4 a rising edge and code 6 either edge. The pending bit becomes visible after the third rising clock edge that follows the pad change.
- R5: Code 0 (low level) and code 1 (high level) set the pending bit on every cycle the level is present. A clear therefore only sticks once the level has gone.
- R6: Codes 3, 5 and 7 to 15 detect nothing on either edge or on either level.
- R7: Writing the pending word clears exactly the bits written as 1 and leaves the others alone. Pending bits never clear by any other means and never set without a detected event.
- R8: The mask does not stop pending capture. A blocked line still latches its event but drives no request.
- R9: Request 0 covers lines 0–3, request 1 lines 4–11, request 2 lines 12–19 and request 3 lines 20–27.
- R10: A request is high exactly when some line of its range is pending and unmasked. It follows mask and pending writes in the cycle after the write edge, with no added register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_in | input | 28 | Asynchronous pad lines, idle high |
| bus_addr | input | 4 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_out | output | 4 | Combined level requests, one per line range |

## Verification
A wrong trigger decode or a wrong field position shows up as an unexpected pending pattern three cycles after a pad change. A field wired to the wrong line pair shows up the same way, because lines of the same pair always move together. A pending bit that clears on a zero write, or that refuses to clear once its level has gone, is visible on the next read of the pending word. Wrong group ranges or wrong mask polarity show on irq_out in the very cycle after a mask write, and the bench sweeps the end lines of every range for this.

// File: rtl/wic_pkg.sv
package wic_pkg;
    localparam int NLINES      = 28;
    localparam int NGROUPS     = 4;
    localparam int FIELD_W     = 4;
    localparam int NFIELDS     = NLINES / 2;
    localparam int LO_FIELDS   = 8;
    localparam int HI_W        = (NFIELDS - LO_FIELDS) * FIELD_W;
    localparam int ADDR_W      = 4;
    localparam int DATA_W      = 32;
    localparam int FIRST_GROUP = 4;
    localparam int GROUP_W     = 8;

    typedef enum logic [3:0] {
        TRG_LOW  = 4'd0,
        TRG_HIGH = 4'd1,
        TRG_FALL = 4'd2,
        TRG_RISE = 4'd4,
        TRG_BOTH = 4'd6
    } trig_e;

    typedef enum logic [1:0] {
        SEL_CFG_LO = 2'd0,
        SEL_CFG_HI = 2'd1,
        SEL_MASK   = 2'd2,
        SEL_PEND   = 2'd3
    } reg_sel_e;

    function automatic logic code_valid(logic [3:0] code);
        return (code == TRG_LOW) || (code == TRG_HIGH) || (code == TRG_FALL) ||
               (code == TRG_RISE) || (code == TRG_BOTH);
    endfunction

    function automatic logic trig_hit(logic [3:0] code, logic cur, logic prev);
        logic h;
        case (code)
            TRG_LOW:  h = !cur;
            TRG_HIGH: h = cur;
            TRG_FALL: h = prev && !cur;
            TRG_RISE: h = !prev && cur;
            TRG_BOTH: h = prev != cur;
            default:  h = 1'b0;
        endcase
        return h;
    endfunction

    function automatic logic [NLINES-1:0] group_lines(int g);
        logic [NLINES-1:0] m;
        int lo;
        int hi;
        lo = (g == 0) ? 0 : FIRST_GROUP + (g - 1) * GROUP_W;
        hi = (g == 0) ? FIRST_GROUP - 1 : lo + GROUP_W - 1;
        m = '0;
        for (int k = 0; k < NLINES; k++) begin
            m[k] = (k >= lo) && (k <= hi);
        end
        return m;
    endfunction
endpackage

// File: rtl/wic_sync.sv
module wic_sync #(
    parameter int N = 28
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pad_i,
    output logic [N-1:0] cur_o,
    output logic [N-1:0] prev_o
);
    logic [N-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '1;
            cur_o  <= '1;
            prev_o <= '1;
        end else begin
            meta_q <= pad_i;
            cur_o  <= meta_q;
            prev_o <= cur_o;
        end
    end
endmodule

// File: rtl/wic_detect.sv
module wic_detect
    import wic_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NFIELDS*FIELD_W-1:0] cfg_i,
    input  logic [NLINES-1:0]          cur_i,
    input  logic [NLINES-1:0]          prev_i,
    output logic [NLINES-1:0]          hit_o
);
    for (genvar i = 0; i < NLINES; i++) begin : g_line
        logic [FIELD_W-1:0] fcode;
        assign fcode    = cfg_i[FIELD_W*(i/2) +: FIELD_W];
        assign hit_o[i] = trig_hit(fcode, cur_i[i], prev_i[i]);

        // R6: a reserved code never produces an event
        a_r6_reserved_silent: assert property (@(posedge clk) disable iff (rst)
            !code_valid(fcode) |-> !hit_o[i]);
    end
endmodule

// File: rtl/wic_regs.sv
module wic_regs
    import wic_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic                       we_i,
    input  logic [DATA_W-1:0]          wdata_i,
    input  logic [NLINES-1:0]          hit_i,
    output logic [DATA_W-1:0]          rdata_o,
    output logic [NFIELDS*FIELD_W-1:0] cfg_o,
    output logic [NLINES-1:0]          mask_o,
    output logic [NLINES-1:0]          pend_o
);
    logic [LO_FIELDS*FIELD_W-1:0] cfg_lo_q;
    logic [HI_W-1:0]              cfg_hi_q;
    logic [NLINES-1:0]            mask_q;
    logic [NLINES-1:0]            pend_q;
    logic [NLINES-1:0]            clr_vec;
    logic                         aligned;
    reg_sel_e                     sel;

    assign aligned = (addr_i[1:0] == 2'b00);
    assign sel     = reg_sel_e'(addr_i[3:2]);
    assign clr_vec = (we_i && aligned && sel == SEL_PEND) ? wdata_i[NLINES-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_lo_q <= '0;
            cfg_hi_q <= '0;
            mask_q   <= '1;
            pend_q   <= '0;
        end else begin
            if (we_i && aligned) begin
                case (sel)
                    SEL_CFG_LO: cfg_lo_q <= wdata_i[LO_FIELDS*FIELD_W-1:0];
                    SEL_CFG_HI: cfg_hi_q <= wdata_i[HI_W-1:0];
                    SEL_MASK:   mask_q   <= wdata_i[NLINES-1:0];
                    default:    ;
                endcase
            end
            pend_q <= (pend_q & ~clr_vec) | hit_i;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (aligned) begin
            case (sel)
                SEL_CFG_LO: rdata_o = DATA_W'(cfg_lo_q);
                SEL_CFG_HI: rdata_o = DATA_W'(cfg_hi_q);
                SEL_MASK:   rdata_o = DATA_W'(mask_q);
                default:    rdata_o = DATA_W'(pend_q);
            endcase
        end
    end

    assign cfg_o  = {cfg_hi_q, cfg_lo_q};
    assign mask_o = mask_q;
    assign pend_o = pend_q;

    // R1: reset leaves all lines blocked and nothing pending
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (mask_q == '1 && pend_q == '0));

    // R7: a pending bit only drops where a one was written to it
    a_r7_clear_only_w1c: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(pend_q) & ~pend_q & ~$past(clr_vec)) == '0));

    // R7: a pending bit only rises where an event was detected
    a_r7_set_only_hit: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(hit_i)) == '0));

    // R2: unused upper bits of mask and pending read zero
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
        addr_i[3] |-> (rdata_o[DATA_W-1:NLINES] == '0));
endmodule

// File: rtl/wake_irq_ctrl.sv
module wake_irq_ctrl
    import wic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] pad_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NGROUPS-1:0] irq_out
);
    logic [NLINES-1:0]          cur;
    logic [NLINES-1:0]          prev;
    logic [NLINES-1:0]          hit;
    logic [NLINES-1:0]          mask;
    logic [NLINES-1:0]          pend;
    logic [NFIELDS*FIELD_W-1:0] cfg;
    logic [NLINES-1:0]          live;

    wic_sync #(.N(NLINES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pad_i  (pad_in),
        .cur_o  (cur),
        .prev_o (prev)
    );

    wic_detect u_detect (
        .clk    (clk),
        .rst    (rst),
        .cfg_i  (cfg),
        .cur_i  (cur),
        .prev_i (prev),
        .hit_o  (hit)
    );

    wic_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr_i  (bus_addr),
        .we_i    (bus_we),
        .wdata_i (bus_wdata),
        .hit_i   (hit),
        .rdata_o (bus_rdata),
        .cfg_o   (cfg),
        .mask_o  (mask),
        .pend_o  (pend)
    );

    assign live = pend & ~mask;

    for (genvar g = 0; g < NGROUPS; g++) begin : g_irq
        localparam logic [NLINES-1:0] RANGE = group_lines(g);
        assign irq_out[g] = |(live & RANGE);
    end

    // R8: with every line blocked no request is raised
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (mask == '1) |-> (irq_out == '0));

    // R10: a request never appears without a pending bit behind it
    a_r10_irq_needs_pend: assert property (@(posedge clk) disable iff (rst)
        (irq_out != '0) |-> (pend != '0));
endmodule

// File: tb/tb_wake_irq_ctrl.sv
module tb_wake_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [27:0] pad = '1;
    logic [3:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  irq;
    int checks = 0;
    int errors = 0;

    localparam logic [3:0] A_CLO = 4'h0, A_CHI = 4'h4, A_MSK = 4'h8, A_PND = 4'hC;
    localparam logic [31:0] ALL = 32'h0FFF_FFFF;

    wake_irq_ctrl dut (
        .clk(clk), .rst(rst), .pad_in(pad), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_out(irq)
    );

    always #5 clk = ~clk;

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    function automatic logic exp_hit(int code, logic o, logic n);
        case (code)
            2: return o && !n;
            4: return !o && n;
            6: return o != n;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [3:0] exp_irq(logic [27:0] p, logic [27:0] m);
        logic [27:0] l;
        l = p & ~m;
        return {|(l & 28'hFF00000), |(l & 28'h00FF000), |(l & 28'h0000FF0), |(l & 28'h000000F)};
    endfunction

    initial begin
        logic [31:0] v;
        int codes[8];
        codes = '{2, 4, 6, 3, 5, 7, 9, 15};
        void'($urandom(32'd2024));
        wait_cyc(3);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(A_CLO, v); chk("R1 cfg_lo", v, 0);
        rd(A_CHI, v); chk("R1 cfg_hi", v, 0);
        rd(A_MSK, v); chk("R1 mask", v, ALL);
        rd(A_PND, v); chk("R1 pend", v, 0);
        chk("R1 irq", {28'd0, irq}, 0);

        // R2 read-as-zero bits and misaligned access
        wr(A_MSK, 32'hFFFF_FFFF); rd(A_MSK, v); chk("R2 mask upper", v, ALL);
        wr(A_CHI, 32'hFFFF_FFFF); rd(A_CHI, v); chk("R2 cfg_hi upper", v, 32'h00FF_FFFF);
        wr(A_CHI, 0);
        wr(4'h9, 0); rd(A_MSK, v); chk("R2 misaligned write ignored", v, ALL);
        rd(4'h9, v); chk("R2 misaligned read zero", v, 0);

        // R4 falling edge timing on line 0, unmasked
        wr(A_CLO, 32'h2);
        wr(A_MSK, ALL & ~32'h1);
        pad[0] = 1'b0;
        wait_cyc(2); rd(A_PND, v); chk("R4 not yet after two edges", v, 0);
        wait_cyc(1); rd(A_PND, v); chk("R4 set after third edge", v, 32'h3 & 32'h1);
        chk("R10 irq follows pending", {28'd0, irq}, 32'h1);
        pad[0] = 1'b1;
        wait_cyc(4);
        wr(A_PND, 32'h1); rd(A_PND, v); chk("R4 no rising with falling code", v, 0);
        chk("R10 irq drops with pending", {28'd0, irq}, 0);
        wr(A_MSK, ALL);

        // R4 rising and both-edge codes
        wr(A_CLO, 32'h642);
        pad[5:0] = 6'b000000;
        wait_cyc(4); rd(A_PND, v); chk("R4 falling/both on fall", v, 32'h33);
        wr(A_PND, 32'h3F);
        pad[5:0] = 6'b111111;
        wait_cyc(4); rd(A_PND, v); chk("R4 rising/both on rise", v, 32'h3C);
        wr(A_PND, 32'h3F);

        // R3 pair sharing and R5 level behaviour
        wr(A_CLO, 32'h0);
        pad[6] = 1'b0;
        wait_cyc(4); rd(A_PND, v); chk("R5 low level line 6 only", v, 32'h40);
        wr(A_CLO, 32'h100);
        wait_cyc(3); rd(A_PND, v); chk("R3 high code sets pair 4,5", v, 32'h70);
        wr(A_PND, 32'h70); rd(A_PND, v); chk("R5 clear does not stick while level", v, 32'h70);
        pad[6] = 1'b1;
        wr(A_CLO, 32'h0);
        wait_cyc(4);
        wr(A_PND, 32'h70); rd(A_PND, v); chk("R5 clear sticks after level", v, 0);

        // R6 reserved codes
        wr(A_CLO, 32'h3579_F35F);
        wr(A_CHI, 32'h00F7_5393);
        pad = '0; wait_cyc(5);
        pad = '1; wait_cyc(5);
        rd(A_PND, v); chk("R6 reserved detects nothing", v, 0);

        // R8 capture while masked, R9 ranges
        wr(A_CLO, 32'h2222_2222);
        wr(A_CHI, 32'h0022_2222);
        pad = '0; wait_cyc(5);
        rd(A_PND, v); chk("R8 pending captured while masked", v, ALL);
        chk("R8 no request while masked", {28'd0, irq}, 0);
        foreach (codes[k]) begin
            int lines[8];
            lines = '{0, 3, 4, 11, 12, 19, 20, 27};
            wr(A_MSK, ALL & ~(32'h1 << lines[k]));
            chk($sformatf("R9 line %0d range", lines[k]), {28'd0, irq},
                {28'd0, exp_irq(28'hFFFFFFF, ALL[27:0] & ~(28'h1 << lines[k]))});
        end
        wr(A_MSK, ALL);

        // R7 write-one-to-clear
        wr(A_PND, 0); rd(A_PND, v); chk("R7 zero write keeps bits", v, ALL);
        wr(A_PND, 32'h00F0_F00F); rd(A_PND, v); chk("R7 partial clear", v, 32'h0F0F_0FF0);
        pad = '1; wait_cyc(5);
        wr(A_PND, ALL); rd(A_PND, v); chk("R7 full clear", v, 0);

        // random edge and reserved codes against the model (R4, R6, R10)
        for (int it = 0; it < 40; it++) begin
            int fld[14];
            logic [31:0] w0, w1, m, e;
            logic [27:0] p0, p1;
            w0 = 0; w1 = 0;
            for (int k = 0; k < 14; k++) begin
                fld[k] = codes[$urandom % 8];
                if (k < 8) w0 |= 32'(fld[k]) << (4 * k);
                else       w1 |= 32'(fld[k]) << (4 * (k - 8));
            end
            m  = $urandom & ALL;
            p0 = 28'($urandom);
            p1 = 28'($urandom);
            wr(A_CLO, w0); wr(A_CHI, w1); wr(A_MSK, m);
            pad = p0; wait_cyc(5);
            wr(A_PND, ALL);
            pad = p1; wait_cyc(4);
            e = 0;
            for (int l = 0; l < 28; l++) e[l] = exp_hit(fld[l / 2], p0[l], p1[l]);
            rd(A_PND, v); chk("R4 random pending", v, e);
            chk("R10 random irq", {28'd0, irq}, {28'd0, exp_irq(e[27:0], m[27:0])});
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule